// File: doc/BRIEF.md
# Gated Square-Wave Frequency Synthesizer

This block is a numerically controlled square-wave source. A 24-bit phase register gains a programmable step on every reference clock. The top bit of that register is the square wave. The output frequency is `f_ref * step / 2^24`. With a reference near 3 MHz, this gives sub-hertz resolution. Software can load a new step at any time through a one-cycle write strobe. The new step takes effect on the next accumulation, and the phase carries on from where it is, with no restart. A separate single-cycle clear pulse returns the phase to zero when a known starting point is wanted.

The block has three outputs, all at the same frequency. `wave_main` is the registered top phase bit. `wave_inv` is its exact complement and changes on the same edge. `wave_gated` is a copy of `wave_main` that `gate_en` switches on and off. A four-state machine controls the gated copy so that it never emits a shortened pulse. The states are:

- GATE_OFF: output held low.
- GATE_ARM: enabled while the wave is high, so the machine waits for a low phase.
- GATE_RUN: the copy follows the wave.
- GATE_DRAIN: disabled while the wave is high, so the machine finishes the current pulse.

The transitions are:

- OFF→RUN when enabled with the wave low.
- OFF→ARM when enabled with the wave high.
- ARM→RUN when the wave is low.
- ARM→OFF when the enable drops.
- RUN→OFF when disabled with the wave low.
- RUN→DRAIN when disabled with the wave high.
- DRAIN→OFF when the wave is low.
- DRAIN→RUN when enabled again.

Top module: `dds_square_gen`

## Requirements
- R1: While `rst_n` is low, and after its release, the phase and the step are zero, `wave_main` is 0, `wave_inv` is 1 and `wave_gated` is 0.
- R2: On each clock edge without a clear, the phase becomes (phase + step) mod 2^24. `wave_main` is the phase's bit 23 as it stood before that edge, so it lags the phase by one register.
- R3: `wave_inv` is always the complement of `wave_main`.
- R4: A cycle with `step_wr` high loads `step_data` into the step register. The next accumulation uses the new step, and the phase is not cleared.
- R5: A cycle with `phase_clr` high makes the phase zero after that edge. If `step_wr` is also high in that cycle, the new step is still loaded.
- R6: A step of zero holds the phase, and therefore all outputs, constant.
- R7: `wave_gated` is 0 in GATE_OFF and GATE_ARM. It equals `wave_main` in GATE_RUN and GATE_DRAIN. It is never high while `wave_main` is low.
- R8: `wave_gated` rises only on an edge where `wave_main` rises, and falls only on an edge where `wave_main` falls. The gate state machine follows the transitions listed above, using `gate_en` and phase bit 23 sampled at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_clr | input | 1 | Synchronous single-cycle phase clear |
| step_wr | input | 1 | Step register write strobe |
| step_data | input | 24 | New step value |
| gate_en | input | 1 | Enable for the gated output |
| wave_main | output | 1 | Primary square wave |
| wave_inv | output | 1 | Antiphase square wave |
| wave_gated | output | 1 | Enable-gated square wave |

## Verification
Some behaviours are checked by assertions on every cycle:
- the complement relation between the two main outputs;
- the gated copy never being high without the main wave;
- the gated copy changing only together with the main wave;
- the clear and write effects on the phase and step registers;
- the frozen phase under a zero step.

Other behaviours only the bench scenarios can show, because they need an independent cycle-by-cycle model of the phase:
- that the wave period matches the step;
- that a mid-run step change continues without a phase jump;
- that the arm and drain paths produce whole pulses.

// File: rtl/dds_pkg.sv
package dds_pkg;
    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_ARM   = 2'd1,
        GATE_RUN   = 2'd2,
        GATE_DRAIN = 2'd3
    } gate_state_t;
endpackage

// File: rtl/dds_step_reg.sv
module dds_step_reg #(
    parameter int STEP_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [STEP_W-1:0] wr_data,
    output logic [STEP_W-1:0] step
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  step <= '0;
        else if (wr) step <= wr_data;
    end

    AST_STEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> step == $past(wr_data)); // R4
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(step)); // R4
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase,
    output logic             phase_msb
);
    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] phase_nxt;

    always_comb begin
        phase_nxt = phase + step;
        if (clr) phase_nxt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase_nxt;
    end

    assign phase_msb = phase[MSB];

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> phase == '0); // R5
    AST_ZERO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step == '0) |=> $stable(phase)); // R6
endmodule

// File: rtl/dds_out_stage.sv
module dds_out_stage
    import dds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msb,
    input  logic gate_en,
    output logic wave_main,
    output logic wave_inv,
    output logic wave_gated
);
    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF:   if (gate_en)   state_d = msb ? GATE_ARM : GATE_RUN;
            GATE_ARM:   if (!gate_en)  state_d = GATE_OFF;
                        else if (!msb) state_d = GATE_RUN;
            GATE_RUN:   if (!gate_en)  state_d = msb ? GATE_DRAIN : GATE_OFF;
            GATE_DRAIN: if (gate_en)   state_d = GATE_RUN;
                        else if (!msb) state_d = GATE_OFF;
            default:                   state_d = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_main  <= 1'b0;
            wave_inv   <= 1'b1;
            wave_gated <= 1'b0;
        end else begin
            wave_main  <= msb;
            wave_inv   <= !msb;
            wave_gated <= msb && (state_d == GATE_RUN || state_d == GATE_DRAIN);
        end
    end

    AST_ANTIPHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wave_inv != wave_main); // R3
    AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        wave_gated |-> wave_main); // R7
    AST_GATED_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_OFF || state_q == GATE_ARM) |-> !wave_gated); // R7
    AST_GATED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wave_gated) |-> $rose(wave_main)); // R8
    AST_GATED_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wave_gated) |-> $fell(wave_main)); // R8
endmodule

// File: rtl/dds_square_gen.sv
module dds_square_gen #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_clr,
    input  logic             step_wr,
    input  logic [ACC_W-1:0] step_data,
    input  logic             gate_en,
    output logic             wave_main,
    output logic             wave_inv,
    output logic             wave_gated
);
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase;
    logic             msb;

    dds_step_reg #(.STEP_W(ACC_W)) u_step (
        .clk(clk), .rst_n(rst_n), .wr(step_wr), .wr_data(step_data), .step(step)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr), .step(step),
        .phase(phase), .phase_msb(msb)
    );

    dds_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .msb(msb), .gate_en(gate_en),
        .wave_main(wave_main), .wave_inv(wave_inv), .wave_gated(wave_gated)
    );

    AST_CLR_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_clr && step_wr) |=> (phase == '0 && step == $past(step_data))); // R5
endmodule

// File: tb/dds_square_gen_bench.sv
`timescale 1ns/1ps
module dds_square_gen_bench;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         phase_clr = 1'b0;
    logic         step_wr = 1'b0;
    logic [W-1:0] step_data = '0;
    logic         gate_en = 1'b0;
    logic         wave_main, wave_inv, wave_gated;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // independent model of the requirements
    logic [W-1:0] m_phase = '0;
    logic [W-1:0] m_step = '0;
    int           m_gs = 0;   // 0 off, 1 arm, 2 run, 3 drain
    logic         m_main = 1'b0;
    logic         m_inv = 1'b1;
    logic         m_gated = 1'b0;
    string        tag = "R1";

    always #5 clk = ~clk;

    dds_square_gen u_dds_square_gen (
        .clk(clk), .rst_n(rst_n), .phase_clr(phase_clr), .step_wr(step_wr),
        .step_data(step_data), .gate_en(gate_en),
        .wave_main(wave_main), .wave_inv(wave_inv), .wave_gated(wave_gated)
    );

    function automatic int gate_next(int s, logic en, logic m);
        case (s)
            0: return en ? (m ? 1 : 2) : 0;
            1: return !en ? 0 : (!m ? 2 : 1);
            2: return !en ? (m ? 3 : 0) : 2;
            default: return en ? 2 : (!m ? 0 : 3);
        endcase
    endfunction

    task automatic check(string r, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", r, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic m;
        int ns;
        m  = m_phase[W-1];
        ns = gate_next(m_gs, gate_en, m);
        m_main  = m;
        m_inv   = !m;
        m_gated = m && (ns >= 2);
        m_gs    = ns;
        m_phase = phase_clr ? '0 : m_phase + m_step;
        if (step_wr) m_step = step_data;
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step1(logic clr, logic wr, logic [W-1:0] d, logic en);
        phase_clr = clr; step_wr = wr; step_data = d; gate_en = en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, wave_main, m_main);
        check("R3", wave_inv, m_inv);
        check((m_gs == 1 || m_gs == 3) ? "R8" : "R7", wave_gated, m_gated);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", wave_main, 1'b0);
        check("R1", wave_inv, 1'b1);
        check("R1", wave_gated, 1'b0);
        rst_n = 1'b1;
        tag = "R1";
        step1(0, 0, '0, 0);
        // R6: zero step holds outputs
        tag = "R6";
        repeat (8) step1(0, 0, '0, 1);
        // R4: load half-scale step, toggles every cycle
        tag = "R4";
        step1(0, 1, 24'h800000, 1);
        repeat (6) step1(0, 0, '0, 1);
        // R4: change step mid-run without clear
        step1(0, 1, 24'h200000, 1);
        repeat (12) step1(0, 0, '0, 1);
        // R5: clear together with a write
        tag = "R5";
        step1(1, 1, 24'h100000, 1);
        repeat (20) step1(0, 0, '0, 1);
        step1(1, 0, '0, 1);
        repeat (4) step1(0, 0, '0, 1);
        // R8: enable/disable while the wave is high
        tag = "R8";
        step1(0, 1, 24'h040000, 0);
        for (int k = 0; k < 200; k++) step1(0, 0, '0, ((k / 23) % 2) == 0);
        // R2: constrained random
        tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            logic [W-1:0] d;
            logic wr, clr, en;
            d   = ($urandom_range(0, 3) == 0) ? W'($urandom) : W'($urandom_range(0, 24'h0FFFFF));
            wr  = ($urandom_range(0, 99) < 3);
            clr = ($urandom_range(0, 199) < 1);
            en  = ($urandom_range(0, 19) == 0) ? !gate_en : gate_en;
            step1(clr, wr, d, en);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule